// File: doc/BRIEF.md
# Hashed Page Table Walker

This block handles a translation-buffer miss by searching an inverted page table in memory that is indexed by a hash. A request carries a virtual page number and a process identifier. The walker hashes the pair to pick a slot and reads that slot's page-table words one at a time. It stops at the first valid word whose process and page tags both equal the request. When the first slot holds no such word, the walker forms a second slot index from a complementary hash and searches that slot in the same way. It then answers with the physical page number, or with a miss so that software can consult its full table.

The walker handles one request at a time. Toward the translation buffer it has a valid-qualified request and a one-cycle response pulse, with `busy` high while a walk is running. Toward memory it has a single-word read port with a fixed one-cycle read latency. The entry address is the slot index in the upper bits and the entry index in the lower bits.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `busy`, `resp_valid`, `resp_hit` and `mem_rd_en` are low, and `resp_ppn` is zero.
- R2: The first read of a walk goes to the primary slot. The primary slot is the low SLOT_BITS bits of the VPN XORed with the low bits of the PID, zero-extended when the PID is narrower. The read address is `{slot, entry_index}`, with the entry index in the low log2(SLOT_ENTRIES) bits (3 bits by default).
- R3: Entries in a slot are read in ascending index order, starting at 0. Each read is one cycle of `mem_rd_en`. `mem_rdata` is taken in the cycle after the read, so a read occurs every second cycle, in cycles 1, 3, 5 … after acceptance.
- R4: A PTE word is laid out as {valid (MSB), PID, VPN, PPN (LSBs)}, with PID 8, VPN 20 and PPN 16 bits by default. A word matches only when valid is 1 and both its PID and its VPN equal the request. An invalid word, or a word with only one tag equal, never matches.
- R5: On the first matching entry the search stops, with no further reads. In the next cycle `resp_valid` pulses with `resp_hit`=1 and `resp_ppn` set to that entry's PPN.
- R6: When none of the primary slot's entries match, the alternate slot, which is the bitwise complement of the primary slot index, is searched from entry 0 in the same way.
- R7: When neither slot matches, the response comes after exactly 2×SLOT_ENTRIES reads (16 by default), with `resp_hit`=0 and `resp_ppn`=0.
- R8: `busy` is high from the cycle after a request is accepted up to the response cycle, and low in the response cycle. A request is accepted only when `busy` is low. `req_valid` asserted while busy starts no walk and has no effect on the walk in progress.
- R9: `resp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process identifier of the request |
| busy | output | 1 | A walk is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Translation found |
| resp_ppn | output | PPN_W | Physical page number on a hit, zero on a miss |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | SLOT_BITS+log2(SLOT_ENTRIES) | Entry address {slot, index} |
| mem_rdata | input | 1+PID_W+VPN_W+PPN_W | PTE word, valid one cycle after the read |

## Verification
The assertions check several properties on every cycle. Every memory read is followed by a cycle without a read. Responses are single pulses and never overlap `busy`. A hit response carries the PPN that the compare logic produced in the previous cycle. A miss is reported only after the full count of reads across both slots. The bench's scenarios are needed for the rest: the hash values and the exact address sequence, the stop at the first of several candidate entries, the rejection of invalid entries and of entries that match on one tag only, the fall-through to the alternate slot, and the ignoring of requests made during a walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_READ  = 2'd1,
      WK_CHECK = 2'd2
   } walk_st_e;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int SLOT_BITS = 6,
   parameter int PLO_W     = 6
) (
   input  logic [SLOT_BITS-1:0] vpn_lo,
   input  logic [PLO_W-1:0]     pid_lo,
   output logic [SLOT_BITS-1:0] slot_pri,
   output logic [SLOT_BITS-1:0] slot_alt
);

   logic [SLOT_BITS-1:0] pid_ext;

   generate
      if (PLO_W > SLOT_BITS) begin : g_bad
         $error("hpt_hash: PLO_W must not exceed SLOT_BITS");
      end else if (PLO_W == SLOT_BITS) begin : g_same
         assign pid_ext = pid_lo;
      end else begin : g_pad
         assign pid_ext = {{(SLOT_BITS-PLO_W){1'b0}}, pid_lo};
      end
   endgenerate

   always_comb begin
      slot_pri = vpn_lo ^ pid_ext;
      slot_alt = ~slot_pri;
   end

endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
   parameter int VPN_W = 20,
   parameter int PID_W = 8,
   parameter int PPN_W = 16,
   localparam int WORD_W = 1 + PID_W + VPN_W + PPN_W
) (
   input  logic [WORD_W-1:0] word,
   input  logic [VPN_W-1:0]  want_vpn,
   input  logic [PID_W-1:0]  want_pid,
   output logic              hit,
   output logic [PPN_W-1:0]  ppn
);

   localparam int PPN_LO = 0;
   localparam int VPN_LO = PPN_W;
   localparam int PID_LO = PPN_W + VPN_W;
   localparam int VLD_B  = WORD_W - 1;

   logic             w_valid;
   logic [PID_W-1:0] w_pid;
   logic [VPN_W-1:0] w_vpn;

   always_comb begin
      w_valid = word[VLD_B];
      w_pid   = word[PID_LO +: PID_W];
      w_vpn   = word[VPN_LO +: VPN_W];
      ppn     = word[PPN_LO +: PPN_W];
      hit     = w_valid && (w_pid == want_pid) && (w_vpn == want_vpn);
   end

endmodule

// File: rtl/hpt_seq.sv
module hpt_seq
   import hpt_pkg::*;
#(
   parameter int SLOT_BITS    = 6,
   parameter int SLOT_ENTRIES = 8,
   parameter int VPN_W        = 20,
   parameter int PID_W        = 8,
   parameter int PPN_W        = 16,
   localparam int IDX_W  = $clog2(SLOT_ENTRIES),
   localparam int ADDR_W = SLOT_BITS + IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [VPN_W-1:0]     req_vpn,
   input  logic [PID_W-1:0]     req_pid,
   input  logic [SLOT_BITS-1:0] slot_pri,
   input  logic [SLOT_BITS-1:0] slot_alt,
   input  logic                 entry_hit,
   input  logic [PPN_W-1:0]     entry_ppn,
   output logic [VPN_W-1:0]     lat_vpn,
   output logic [PID_W-1:0]     lat_pid,
   output logic                 busy,
   output logic                 mem_rd_en,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 resp_valid,
   output logic                 resp_hit,
   output logic [PPN_W-1:0]     resp_ppn
);

   localparam int            MAX_RD = 2 * SLOT_ENTRIES;
   localparam int            CNT_W  = $clog2(MAX_RD + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_ENTRIES - 1);

   walk_st_e         state;
   logic [IDX_W-1:0] idx;
   logic             on_alt;
   logic [CNT_W-1:0] rd_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= WK_IDLE;
         idx        <= '0;
         on_alt     <= 1'b0;
         rd_cnt     <= '0;
         lat_vpn    <= '0;
         lat_pid    <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_ppn   <= '0;
      end else begin
         resp_valid <= 1'b0;
         case (state)
            WK_IDLE: begin
               if (req_valid) begin
                  lat_vpn <= req_vpn;
                  lat_pid <= req_pid;
                  idx     <= '0;
                  on_alt  <= 1'b0;
                  rd_cnt  <= '0;
                  state   <= WK_READ;
               end
            end
            WK_READ: begin
               rd_cnt <= rd_cnt + CNT_W'(1);
               state  <= WK_CHECK;
            end
            WK_CHECK: begin
               if (entry_hit) begin
                  resp_valid <= 1'b1;
                  resp_hit   <= 1'b1;
                  resp_ppn   <= entry_ppn;
                  state      <= WK_IDLE;
               end else if (idx == LAST_IDX) begin
                  if (!on_alt) begin
                     on_alt <= 1'b1;
                     idx    <= '0;
                     state  <= WK_READ;
                  end else begin
                     resp_valid <= 1'b1;
                     resp_hit   <= 1'b0;
                     resp_ppn   <= '0;
                     state      <= WK_IDLE;
                  end
               end else begin
                  idx   <= idx + IDX_W'(1);
                  state <= WK_READ;
               end
            end
            default: state <= WK_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (state != WK_IDLE);
      mem_rd_en = (state == WK_READ);
      mem_addr  = {(on_alt ? slot_alt : slot_pri), idx};
   end

   // R3
   rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R7
   miss_after_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (rd_cnt == CNT_W'(MAX_RD)));

   // R7
   rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= CNT_W'(MAX_RD));

   // R9
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
   parameter int SLOT_BITS    = 6,
   parameter int SLOT_ENTRIES = 8,
   parameter int VPN_W        = 20,
   parameter int PID_W        = 8,
   parameter int PPN_W        = 16,
   localparam int IDX_W  = $clog2(SLOT_ENTRIES),
   localparam int ADDR_W = SLOT_BITS + IDX_W,
   localparam int WORD_W = 1 + PID_W + VPN_W + PPN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [PID_W-1:0]  req_pid,
   output logic              busy,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [PPN_W-1:0]  resp_ppn,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata
);

   localparam int PLO_W = (PID_W < SLOT_BITS) ? PID_W : SLOT_BITS;

   generate
      if (SLOT_ENTRIES < 2 || (1 << IDX_W) != SLOT_ENTRIES) begin : g_bad_entries
         $error("hpt_walker: SLOT_ENTRIES must be a power of two >= 2");
      end
      if (VPN_W < SLOT_BITS || SLOT_BITS < 1) begin : g_bad_slots
         $error("hpt_walker: SLOT_BITS must be in 1..VPN_W");
      end
   endgenerate

   logic [VPN_W-1:0]     lat_vpn;
   logic [PID_W-1:0]     lat_pid;
   logic [SLOT_BITS-1:0] slot_pri;
   logic [SLOT_BITS-1:0] slot_alt;
   logic                 entry_hit;
   logic [PPN_W-1:0]     entry_ppn;

   hpt_hash #(
      .SLOT_BITS (SLOT_BITS),
      .PLO_W     (PLO_W)
   ) u_hash (
      .vpn_lo   (lat_vpn[SLOT_BITS-1:0]),
      .pid_lo   (lat_pid[PLO_W-1:0]),
      .slot_pri (slot_pri),
      .slot_alt (slot_alt)
   );

   hpt_match #(
      .VPN_W (VPN_W),
      .PID_W (PID_W),
      .PPN_W (PPN_W)
   ) u_match (
      .word     (mem_rdata),
      .want_vpn (lat_vpn),
      .want_pid (lat_pid),
      .hit      (entry_hit),
      .ppn      (entry_ppn)
   );

   hpt_seq #(
      .SLOT_BITS    (SLOT_BITS),
      .SLOT_ENTRIES (SLOT_ENTRIES),
      .VPN_W        (VPN_W),
      .PID_W        (PID_W),
      .PPN_W        (PPN_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_vpn    (req_vpn),
      .req_pid    (req_pid),
      .slot_pri   (slot_pri),
      .slot_alt   (slot_alt),
      .entry_hit  (entry_hit),
      .entry_ppn  (entry_ppn),
      .lat_vpn    (lat_vpn),
      .lat_pid    (lat_pid),
      .busy       (busy),
      .mem_rd_en  (mem_rd_en),
      .mem_addr   (mem_addr),
      .resp_valid (resp_valid),
      .resp_hit   (resp_hit),
      .resp_ppn   (resp_ppn)
   );

   // R8
   resp_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !busy);

   // R8
   rd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   // R5
   hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_hit) |-> ($past(entry_hit) && resp_ppn == $past(entry_ppn)));

endmodule

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;

   localparam int SB   = 6;
   localparam int NE   = 8;
   localparam int VW   = 20;
   localparam int PW   = 8;
   localparam int QW   = 16;
   localparam int AW   = SB + 3;
   localparam int WW   = 1 + PW + VW + QW;
   localparam int NMEM = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [VW-1:0] req_vpn = '0;
   logic [PW-1:0] req_pid = '0;
   logic          busy, resp_valid, resp_hit, mem_rd_en;
   logic [QW-1:0] resp_ppn;
   logic [AW-1:0] mem_addr;
   logic [WW-1:0] mem_rdata = '0;

   logic [WW-1:0] mem [NMEM];

   int checks = 0;
   int errs   = 0;
   int unsigned exp_addr[$];

   always #10 clk = ~clk;

   always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

   hpt_walker u_hpt_walker (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_vpn (req_vpn),
      .req_pid (req_pid), .busy (busy), .resp_valid (resp_valid),
      .resp_hit (resp_hit), .resp_ppn (resp_ppn), .mem_rd_en (mem_rd_en),
      .mem_addr (mem_addr), .mem_rdata (mem_rdata)
   );

   task automatic chk(input bit ok, input string r, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", r, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] pte(bit v, int pid, int vpn, int ppn);
      return {v, PW'(pid), VW'(vpn), QW'(ppn)};
   endfunction

   function automatic int hash1(int vpn, int pid);
      return (vpn ^ pid) & ((1 << SB) - 1);
   endfunction

   function automatic int slot_addr(int s, int i);
      return s * NE + i;
   endfunction

   task automatic ref_search(input int vpn, input int pid, output bit hit, output int ppn);
      int slots[2];
      slots[0] = hash1(vpn, pid);
      slots[1] = (~slots[0]) & ((1 << SB) - 1);
      exp_addr.delete();
      hit = 0;
      ppn = 0;
      for (int s = 0; s < 2 && !hit; s++) begin
         for (int i = 0; i < NE && !hit; i++) begin
            logic [WW-1:0] w;
            exp_addr.push_back(slot_addr(slots[s], i));
            w = mem[slot_addr(slots[s], i)];
            if (w[WW-1] && int'(w[WW-2 -: PW]) == pid && int'(w[QW +: VW]) == vpn) begin
               hit = 1;
               ppn = int'(w[QW-1:0]);
            end
         end
      end
   endtask

   task automatic check_idle(input string r);
      chk(!busy, r, busy, 0);
      chk(!resp_valid, r, resp_valid, 0);
      chk(!mem_rd_en, r, mem_rd_en, 0);
   endtask

   task automatic walk(input int vpn, input int pid, input bit poke, input string tag);
      bit hit;
      int ppn, n;
      ref_search(vpn, pid, hit, ppn);
      n = exp_addr.size();
      @(negedge clk);
      req_valid = 1'b1;
      req_vpn   = VW'(vpn);
      req_pid   = PW'(pid);
      @(posedge clk);
      for (int c = 1; c <= 2 * n + 1; c++) begin
         @(negedge clk);
         req_valid = poke && (c < 2 * n + 1);
         req_vpn   = poke ? VW'(vpn + 1) : req_vpn;
         chk(busy == (c <= 2 * n), "R8 busy", busy, c <= 2 * n);
         chk(mem_rd_en == ((c % 2 == 1) && c < 2 * n), "R3 read strobe", mem_rd_en,
             (c % 2 == 1) && c < 2 * n);
         if (mem_rd_en && (c % 2 == 1) && c < 2 * n)
            chk(mem_addr == AW'(exp_addr[(c - 1) / 2]),
                ((c - 1) / 2 < NE) ? {tag, " R2 addr"} : {tag, " R6 addr"},
                mem_addr, exp_addr[(c - 1) / 2]);
         chk(resp_valid == (c == 2 * n + 1), "R9 resp strobe", resp_valid, c == 2 * n + 1);
         if (c == 2 * n + 1) begin
            chk(resp_hit == hit, hit ? {tag, " R5 hit"} : {tag, " R7 miss"}, resp_hit, hit);
            chk(resp_ppn == QW'(ppn), {tag, " R4 ppn"}, resp_ppn, ppn);
         end
      end
      req_valid = 1'b0;
      @(negedge clk);
      check_idle({tag, " R8 R9 after response"});
   endtask

   initial begin
      for (int i = 0; i < NMEM; i++) mem[i] = '0;
      // A: primary slot entry 0
      mem[slot_addr(hash1('h12345, 'h21), 0)] = pte(1, 'h21, 'h12345, 'hBEEF);
      // B: invalid exact tag at 2, pid mismatch at 3, real at 5, another match at 6
      mem[slot_addr(hash1('h0ABCD, 'h07), 2)] = pte(0, 'h07, 'h0ABCD, 'h1111);
      mem[slot_addr(hash1('h0ABCD, 'h07), 3)] = pte(1, 'h08, 'h0ABCD, 'h2222);
      mem[slot_addr(hash1('h0ABCD, 'h07), 4)] = pte(1, 'h07, 'h0ABCE, 'h2323);
      mem[slot_addr(hash1('h0ABCD, 'h07), 5)] = pte(1, 'h07, 'h0ABCD, 'h3333);
      mem[slot_addr(hash1('h0ABCD, 'h07), 6)] = pte(1, 'h07, 'h0ABCD, 'h3434);
      // C: primary full of others, alternate entry 7
      for (int i = 0; i < NE; i++)
         mem[slot_addr(hash1('h00F00, 'h3C), i)] = pte(1, 'h3D, 'h00F00 + i, 'h5000 + i);
      mem[slot_addr((~hash1('h00F00, 'h3C)) & 63, 7)] = pte(1, 'h3C, 'h00F00, 'h4444);
      // E: alternate entry 0
      mem[slot_addr((~hash1('h54321, 'h99)) & 63, 0)] = pte(1, 'h99, 'h54321, 'h0ACE);

      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R1 reset");
      chk(resp_ppn == '0, "R1 reset ppn", resp_ppn, 0);
      chk(!resp_hit, "R1 reset hit", resp_hit, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after release");

      walk('h12345, 'h21, 0, "A");
      walk('h0ABCD, 'h07, 1, "B");
      walk('h00F00, 'h3C, 0, "C");
      walk('h77777, 'h11, 1, "D");
      walk('h54321, 'h99, 0, "E");
      walk('h12345, 'h22, 0, "F");

      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL R8 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

endmodule